// File: doc/BRIEF.md
# Shared-Adder Integer ALU

This block is a purely combinational integer arithmetic-logic unit of parameterized width. It takes two operands and a 4-bit function code. It returns a result of the same width, a carry flag and a signed-overflow flag. It is meant to sit in the execute stage of a small RISC datapath, where the function code comes straight from the instruction decoder.

Addition, subtraction and both less-than comparisons all go through a single ripple-style adder. A subtraction feeds the adder the complement of B and a carry-in of one. The signed and unsigned flavours of an operation produce the same sum. They differ only in how the flags are read to form a comparison. Four bitwise operations use a separate logic slice. A final multiplexer picks which result drives the output. Function codes with no operation assigned give an all-zero result and clear both flags.

Top module: `alu_core`

## Requirements
- R1: Codes 4'b0000 and 4'b0001 give y_o = (a_i + b_i) modulo 2^WIDTH.
- R2: Codes 4'b0010 and 4'b0011 give y_o = (a_i - b_i) modulo 2^WIDTH.
- R3: Code 4'b0100 gives bitwise AND, 4'b0101 gives OR, 4'b0110 gives XOR and 4'b0111 gives NOR of a_i and b_i.
- R4: Code 4'b1010 gives y_o = 1 when a_i < b_i as two's-complement values, else 0. All bits above bit 0 are zero.
- R5: Code 4'b1011 gives y_o = 1 when a_i < b_i as unsigned values, else 0. All bits above bit 0 are zero.
- R6: For codes 4'b0000 to 4'b0011, 4'b1010 and 4'b1011, cout_o is the carry out of the top bit of the shared adder. For addition that is a_i + b_i >= 2^WIDTH. For subtraction and compare it is 1 exactly when a_i >= b_i unsigned.
- R7: For the same six codes, ov_o is 1 exactly when the true two's-complement sum (add codes) or difference (subtract and compare codes) falls outside the signed range of WIDTH bits.
- R8: For codes 4'b0100 to 4'b0111, cout_o and ov_o are both 0.
- R9: Codes 4'b1000, 4'b1001 and 4'b1100 to 4'b1111 give y_o = 0, cout_o = 0 and ov_o = 0.
- R10: For any operands, the signed and unsigned variants of add (0000 vs 0001) and of subtract (0010 vs 0011) give identical y_o, cout_o and ov_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| func_i | input | 4 | Function code |
| y_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry out of the shared adder |
| ov_o | output | 1 | Two's-complement overflow of the shared adder |

## Verification
The bench builds two copies of the block. The first uses WIDTH = 8. It is driven with a table of corner operand pairs (zero, all ones, most-positive, most-negative, and their neighbours) and with random pairs, each under all sixteen function codes. The second uses WIDTH = 4, which is small enough that every operand pair under every code can be applied. That covers every carry and overflow boundary and every signed or unsigned compare tie exhaustively, including the undefined codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    FN_ADD  = 4'b0000,
    FN_ADDU = 4'b0001,
    FN_SUB  = 4'b0010,
    FN_SUBU = 4'b0011,
    FN_AND  = 4'b0100,
    FN_OR   = 4'b0101,
    FN_XOR  = 4'b0110,
    FN_NOR  = 4'b0111,
    FN_SLT  = 4'b1010,
    FN_SLTU = 4'b1011
  } alu_fn_e;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_SUM   = 2'd1,
    RES_LOGIC = 2'd2,
    RES_LESS  = 2'd3
  } res_sel_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'd0,
    LOP_OR  = 2'd1,
    LOP_XOR = 2'd2,
    LOP_NOR = 2'd3
  } logic_op_e;

  typedef struct packed {
    logic      sub;
    logic      unsgn;
    res_sel_e  sel;
    logic_op_e lop;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] func_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o.sub   = 1'b0;
    ctrl_o.unsgn = 1'b0;
    ctrl_o.sel   = RES_NONE;
    ctrl_o.lop   = LOP_AND;
    case (func_i)
      FN_ADD, FN_ADDU: ctrl_o.sel = RES_SUM;
      FN_SUB, FN_SUBU: begin
        ctrl_o.sel = RES_SUM;
        ctrl_o.sub = 1'b1;
      end
      FN_AND: begin ctrl_o.sel = RES_LOGIC; ctrl_o.lop = LOP_AND; end
      FN_OR:  begin ctrl_o.sel = RES_LOGIC; ctrl_o.lop = LOP_OR;  end
      FN_XOR: begin ctrl_o.sel = RES_LOGIC; ctrl_o.lop = LOP_XOR; end
      FN_NOR: begin ctrl_o.sel = RES_LOGIC; ctrl_o.lop = LOP_NOR; end
      FN_SLT, FN_SLTU: begin
        ctrl_o.sel   = RES_LESS;
        ctrl_o.sub   = 1'b1;
        ctrl_o.unsgn = func_i[0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ov_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   total;

  // subtract as a + ~b + 1 on the same carry chain
  assign b_eff = b_i ^ {WIDTH{sub_i}};
  assign total = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};

  assign sum_o  = total[MSB:0];
  assign cout_o = total[WIDTH];
  assign ov_o   = (a_i[MSB] == b_eff[MSB]) && (total[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_op_e        op_i,
  output logic [WIDTH-1:0] y_o
);

  always_comb begin
    case (op_i)
      LOP_AND: y_o = a_i & b_i;
      LOP_OR:  y_o = a_i | b_i;
      LOP_XOR: y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       func_i,
  output logic [WIDTH-1:0] y_o,
  output logic             cout_o,
  output logic             ov_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] lres;
  logic             add_cout;
  logic             add_ov;
  logic             less;
  logic             flags_en;

  alu_decode u_decode (
    .func_i (func_i),
    .ctrl_o (ctrl)
  );

  alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (ctrl.sub),
    .sum_o  (sum),
    .cout_o (add_cout),
    .ov_o   (add_ov)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (ctrl.lop),
    .y_o  (lres)
  );

  // unsigned: borrow out; signed: sign corrected by overflow
  assign less = ctrl.unsgn ? ~add_cout : (sum[MSB] ^ add_ov);

  always_comb begin
    case (ctrl.sel)
      RES_SUM:   y_o = sum;
      RES_LOGIC: y_o = lres;
      RES_LESS:  y_o = {{(WIDTH-1){1'b0}}, less};
      default:   y_o = '0;
    endcase
  end

  assign flags_en = (ctrl.sel == RES_SUM) || (ctrl.sel == RES_LESS);
  assign cout_o   = flags_en & add_cout;
  assign ov_o     = flags_en & add_ov;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       func_i,
  input logic [WIDTH-1:0] y_o,
  input logic             cout_o,
  input logic             ov_o
);

  logic is_add, is_sub, is_logic, is_cmp, is_undef;

  always_comb begin
    is_add   = (func_i[3:1] == 3'b000);
    is_sub   = (func_i[3:1] == 3'b001);
    is_logic = (func_i[3:2] == 2'b01);
    is_cmp   = (func_i[3:1] == 3'b101);
    is_undef = !(is_add || is_sub || is_logic || is_cmp);
  end

  always_comb begin
    assert_add_result_R1: assert (!is_add || (y_o == WIDTH'(a_i + b_i)))
      else $error("add result mismatch");
    assert_sub_result_R2: assert (!is_sub || (y_o == WIDTH'(a_i - b_i)))
      else $error("sub result mismatch");
    assert_cmp_upper_zero_R4: assert (!is_cmp || (y_o[WIDTH-1:1] == '0))
      else $error("compare upper bits set");
    assert_unsigned_less_R5: assert (!(func_i == 4'b1011) || (y_o[0] == (a_i < b_i)))
      else $error("unsigned compare wrong");
    assert_logic_flags_low_R8: assert (!is_logic || (!cout_o && !ov_o))
      else $error("flags set on logic code");
    assert_undef_quiet_R9: assert (!is_undef || ((y_o == '0) && !cout_o && !ov_o))
      else $error("undefined code not quiet");
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_core_test.sv
module alu_core_test;

  localparam int W  = 8;
  localparam int WN = 4;
  localparam int NVEC = 12;
  localparam int NRAND = 200;

  // corner operand pairs {a, b}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0000, 16'hFFFF, 16'h7F7F, 16'h8080,
    16'h7F01, 16'h8001, 16'h807F, 16'h7F80,
    16'hFF01, 16'h00FF, 16'h0001, 16'h8000
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0]  a, b, y;
  logic [3:0]    func;
  logic          cout, ov;
  logic [WN-1:0] an, bn, yn;
  logic [3:0]    funcn;
  logic          coutn, ovn;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  alu_core #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .func_i(func), .y_o(y), .cout_o(cout), .ov_o(ov)
  );

  alu_core #(.WIDTH(WN)) uut_narrow (
    .a_i(an), .b_i(bn), .func_i(funcn), .y_o(yn), .cout_o(coutn), .ov_o(ovn)
  );

  // returns {cout, ov, y[31:0]}
  function automatic logic [33:0] model(int w, logic [31:0] av, logic [31:0] bv, logic [3:0] f);
    longint mask, ua, ub, sa, sb, r, s, smax, smin;
    logic [31:0] yv;
    logic c, o;
    mask = (longint'(1) << w) - 1;
    ua = longint'(av) & mask;
    ub = longint'(bv) & mask;
    sa = ua[w-1] ? ua - (longint'(1) << w) : ua;
    sb = ub[w-1] ? ub - (longint'(1) << w) : ub;
    smax = (longint'(1) << (w-1)) - 1;
    smin = -(longint'(1) << (w-1));
    yv = '0; c = 0; o = 0;
    case (f)
      4'b0000, 4'b0001: begin
        r = ua + ub; s = sa + sb;
        yv = 32'(r & mask); c = r[w]; o = (s > smax) || (s < smin);
      end
      4'b0010, 4'b0011, 4'b1010, 4'b1011: begin
        r = ua + ((~ub) & mask) + 1; s = sa - sb;
        c = r[w]; o = (s > smax) || (s < smin);
        if (f == 4'b1010)      yv = (sa < sb) ? 32'd1 : 32'd0;
        else if (f == 4'b1011) yv = (ua < ub) ? 32'd1 : 32'd0;
        else                   yv = 32'(r & mask);
      end
      4'b0100: yv = 32'(ua & ub);
      4'b0101: yv = 32'(ua | ub);
      4'b0110: yv = 32'(ua ^ ub);
      4'b0111: yv = 32'((~(ua | ub)) & mask);
      default: ;
    endcase
    return {c, o, yv};
  endfunction

  function automatic string tag_for(logic [3:0] f);
    case (f)
      4'b0000, 4'b0001: return "R1/R6/R7";
      4'b0010, 4'b0011: return "R2/R6/R7";
      4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R3/R8";
      4'b1010: return "R4/R6/R7";
      4'b1011: return "R5/R6/R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual cout=%0b ov=%0b y=%h expected cout=%0b ov=%0b y=%h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic apply_wide(logic [W-1:0] av, logic [W-1:0] bv, logic [3:0] f);
    a = av; b = bv; func = f;
    @(negedge clk);
    check($sformatf("%s f=%b a=%h b=%h", tag_for(f), f, av, bv),
          {cout, ov, 24'd0, y}, model(W, 32'(av), 32'(bv), f));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    a = '0; b = '0; func = '0;
    an = '0; bn = '0; funcn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state: zero operands, add code
    check("R1 idle", {cout, ov, 24'd0, y}, 34'd0);
    rst_ni = 1'b1;

    // table of corner pairs under every code
    for (int i = 0; i < NVEC; i++)
      for (int f = 0; f < 16; f++)
        apply_wide(VEC[i][15:8], VEC[i][7:0], 4'(f));

    // random pairs under every code
    for (int i = 0; i < NRAND; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      for (int f = 0; f < 16; f++) apply_wide(ra, rb, 4'(f));
    end

    // R10: signed and unsigned variants agree
    for (int i = 0; i < 40; i++) begin
      logic [W+1:0] o_s, o_u;
      a = W'($urandom); b = W'($urandom);
      for (int k = 0; k < 2; k++) begin
        func = 4'(2*k); @(negedge clk); o_s = {cout, ov, y};
        func = 4'(2*k+1); @(negedge clk); o_u = {cout, ov, y};
        check("R10 variant agreement", 34'(o_u), 34'(o_s));
      end
    end

    // directed: NOR of zeros is all ones, slt most-negative vs most-positive
    apply_wide(8'h00, 8'h00, 4'b0111);
    apply_wide(8'h80, 8'h7F, 4'b1010);
    apply_wide(8'h80, 8'h7F, 4'b1011);
    apply_wide(8'h80, 8'h01, 4'b0010);

    // exhaustive narrow instance
    for (int f = 0; f < 16; f++)
      for (int ia = 0; ia < 16; ia++)
        for (int ib = 0; ib < 16; ib++) begin
          an = 4'(ia); bn = 4'(ib); funcn = 4'(f);
          @(negedge clk);
          check($sformatf("%s narrow f=%b a=%h b=%h", tag_for(4'(f)), funcn, an, bn),
                {coutn, ovn, 28'd0, yn}, model(WN, 32'(ia), 32'(ib), 4'(f)));
        end

    done = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule